// File: doc/BRIEF.md
# Radix-4 Fixed-Point Butterfly

This block is the arithmetic core of one radix-4 step in a fixed-point inverse FFT. It receives four complex data samples and four complex twiddle factors. Each sample is scaled by its own twiddle. The four products are then merged through two layers of complex additions and subtractions to give four complex results. One of these additions takes a difference that is first rotated by the imaginary unit.

The arithmetic path has no storage. A parameter adds an optional output register, which retimes the result behind a valid flag. With the register present, a result appears one clock after the inputs that produced it are accepted. While the flag is low, the register keeps its last result.

The block has no twiddle generation, no data reordering between stages and no stage sequencing. The surrounding transform supplies all of these.

Top module: `r4_bfly`

## Requirements
- R1: Each bus carries four lanes. Lane n occupies bits [32n+31:32n]. Within a lane, the real part is in the upper 16 bits and the imaginary part in the lower 16 bits. Both parts are two's complement.
- R2: Every lane is multiplied by its own twiddle, lane 0 included. A twiddle is a signed Q1.14 value, so 0x4000 stands for 1.0. Each part of the full-precision complex product is shifted right arithmetically by 14 (rounding toward minus infinity) and then truncated to 16 bits.
- R3: Call the lane products p0..p3. The first combining layer forms a = p0+p2, b = p0-p2, c = p1+p3 and d = i·(p1-p3).
- R4: The outputs are lane0 = a+c, lane1 = b+d, lane2 = a-c and lane3 = b-d.
- R5: Rotating a value re + j·im by i yields (-im) + j·re. For example, with unit twiddles and only lane 1 = (100, 0), output lane 1 is (0, 100) and output lane 3 is (0, -100).
- R6: Every addition, subtraction and negation wraps at 16 bits with no saturation. For example, 32767 + 32767 yields -2.
- R7: With the output register enabled (the default), data_o carries the result of the inputs sampled on a rising edge where valid_i is high, starting from that edge.
- R8: valid_o equals the value valid_i had at the previous rising edge.
- R9: At an edge where valid_i is low, data_o keeps its value, whatever data_i and twid_i hold.
- R10: While rst_ni is low, valid_o is low and data_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies data_i and twid_i |
| data_i | input | 128 | Four complex data samples |
| twid_i | input | 128 | Four complex Q1.14 twiddles |
| valid_o | output | 1 | Qualifies data_o |
| data_o | output | 128 | Four complex butterfly results |

## Verification
The assertions expect valid_i, data_i and twid_i to be settled at each rising edge, and they expect reset to be released away from a clock edge. The bench meets both conditions by driving every input on the falling edge. Wrapping is part of the defined behaviour, so inputs and twiddles may take any 16-bit value. The random vectors span the full signed range, including -32768 twiddle parts that lie outside the ±1.0 range. The directed cases cover unit and half-scale twiddles, a pure imaginary twiddle, all-zero data and overflowing sums.

// File: rtl/r4_bfly_pkg.sv
package r4_bfly_pkg;
  localparam int LANES = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;
endpackage

// File: rtl/r4_cmul.sv
module r4_cmul #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic signed [W-1:0] a_re_i,
  input  logic signed [W-1:0] a_im_i,
  input  logic signed [W-1:0] b_re_i,
  input  logic signed [W-1:0] b_im_i,
  output logic signed [W-1:0] p_re_o,
  output logic signed [W-1:0] p_im_o
);
  localparam int PW = 2 * W + 1;

  logic signed [PW-1:0] ar_x, ai_x, br_x, bi_x;
  logic signed [PW-1:0] full_re, full_im;

  always_comb begin
    ar_x = {{(W+1){a_re_i[W-1]}}, a_re_i};
    ai_x = {{(W+1){a_im_i[W-1]}}, a_im_i};
    br_x = {{(W+1){b_re_i[W-1]}}, b_re_i};
    bi_x = {{(W+1){b_im_i[W-1]}}, b_im_i};
    full_re = ar_x * br_x - ai_x * bi_x;
    full_im = ar_x * bi_x + ai_x * br_x;
    p_re_o = W'(full_re >>> FRAC);
    p_im_o = W'(full_im >>> FRAC);
  end
endmodule

// File: rtl/r4_cadd.sv
module r4_cadd
  import r4_bfly_pkg::*;
#(
  parameter int         W  = 16,
  parameter addsub_op_e OP = OP_ADD
) (
  input  logic signed [W-1:0] a_re_i,
  input  logic signed [W-1:0] a_im_i,
  input  logic signed [W-1:0] b_re_i,
  input  logic signed [W-1:0] b_im_i,
  output logic signed [W-1:0] s_re_o,
  output logic signed [W-1:0] s_im_o
);
  // wraps at W bits by design
  if (OP == OP_ADD) begin : g_add
    assign s_re_o = a_re_i + b_re_i;
    assign s_im_o = a_im_i + b_im_i;
  end else begin : g_sub
    assign s_re_o = a_re_i - b_re_i;
    assign s_im_o = a_im_i - b_im_i;
  end
endmodule

// File: rtl/r4_rot_i.sv
module r4_rot_i #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_re_i,
  input  logic signed [W-1:0] a_im_i,
  output logic signed [W-1:0] r_re_o,
  output logic signed [W-1:0] r_im_o
);
  // times i: swap, negate new real
  assign r_re_o = -a_im_i;
  assign r_im_o = a_re_i;
endmodule

// File: rtl/r4_bfly.sv
module r4_bfly
  import r4_bfly_pkg::*;
#(
  parameter int W       = 16,
  parameter int FRAC    = 14,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = 2 * W,
  localparam int VW     = LANES * CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [VW-1:0] data_i,
  input  logic [VW-1:0] twid_i,
  output logic          valid_o,
  output logic [VW-1:0] data_o
);
  logic signed [W-1:0] t_re [LANES];
  logic signed [W-1:0] t_im [LANES];
  logic signed [W-1:0] k_re [LANES];
  logic signed [W-1:0] k_im [LANES];
  logic signed [W-1:0] m_re [LANES];
  logic signed [W-1:0] m_im [LANES];
  logic signed [W-1:0] y_re [LANES];
  logic signed [W-1:0] y_im [LANES];
  logic signed [W-1:0] z_re [LANES];
  logic signed [W-1:0] z_im [LANES];
  logic signed [W-1:0] d_re, d_im;
  logic [VW-1:0]       z_vec;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign t_re[n] = data_i[n*CW+W +: W];
    assign t_im[n] = data_i[n*CW   +: W];
    assign k_re[n] = twid_i[n*CW+W +: W];
    assign k_im[n] = twid_i[n*CW   +: W];

    r4_cmul #(.W(W), .FRAC(FRAC)) u_mul (
      .a_re_i(t_re[n]), .a_im_i(t_im[n]),
      .b_re_i(k_re[n]), .b_im_i(k_im[n]),
      .p_re_o(m_re[n]), .p_im_o(m_im[n])
    );

    assign z_vec[n*CW +: CW] = {z_re[n], z_im[n]};
  end

  // first layer
  r4_cadd #(.W(W), .OP(OP_ADD)) u_y0 (
    .a_re_i(m_re[0]), .a_im_i(m_im[0]), .b_re_i(m_re[2]), .b_im_i(m_im[2]),
    .s_re_o(y_re[0]), .s_im_o(y_im[0]));
  r4_cadd #(.W(W), .OP(OP_SUB)) u_y1 (
    .a_re_i(m_re[0]), .a_im_i(m_im[0]), .b_re_i(m_re[2]), .b_im_i(m_im[2]),
    .s_re_o(y_re[1]), .s_im_o(y_im[1]));
  r4_cadd #(.W(W), .OP(OP_ADD)) u_y2 (
    .a_re_i(m_re[1]), .a_im_i(m_im[1]), .b_re_i(m_re[3]), .b_im_i(m_im[3]),
    .s_re_o(y_re[2]), .s_im_o(y_im[2]));
  r4_cadd #(.W(W), .OP(OP_SUB)) u_d13 (
    .a_re_i(m_re[1]), .a_im_i(m_im[1]), .b_re_i(m_re[3]), .b_im_i(m_im[3]),
    .s_re_o(d_re), .s_im_o(d_im));
  r4_rot_i #(.W(W)) u_rot (
    .a_re_i(d_re), .a_im_i(d_im), .r_re_o(y_re[3]), .r_im_o(y_im[3]));

  // second layer
  r4_cadd #(.W(W), .OP(OP_ADD)) u_z0 (
    .a_re_i(y_re[0]), .a_im_i(y_im[0]), .b_re_i(y_re[2]), .b_im_i(y_im[2]),
    .s_re_o(z_re[0]), .s_im_o(z_im[0]));
  r4_cadd #(.W(W), .OP(OP_ADD)) u_z1 (
    .a_re_i(y_re[1]), .a_im_i(y_im[1]), .b_re_i(y_re[3]), .b_im_i(y_im[3]),
    .s_re_o(z_re[1]), .s_im_o(z_im[1]));
  r4_cadd #(.W(W), .OP(OP_SUB)) u_z2 (
    .a_re_i(y_re[0]), .a_im_i(y_im[0]), .b_re_i(y_re[2]), .b_im_i(y_im[2]),
    .s_re_o(z_re[2]), .s_im_o(z_im[2]));
  r4_cadd #(.W(W), .OP(OP_SUB)) u_z3 (
    .a_re_i(y_re[1]), .a_im_i(y_im[1]), .b_re_i(y_re[3]), .b_im_i(y_im[3]),
    .s_re_o(z_re[3]), .s_im_o(z_im[3]));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        data_o  <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) data_o <= z_vec;
      end
    end
  end else begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = z_vec;
  end
endmodule

// File: rtl/r4_bfly_chk.sv
module r4_bfly_chk #(
  parameter int VW      = 128,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [VW-1:0] data_i,
  input logic [VW-1:0] twid_i,
  input logic          valid_o,
  input logic [VW-1:0] data_o
);
  if (REG_OUT) begin : g_chk
    logic armed;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= 1'b0;
      else         armed <= 1'b1;
    end

    always @(posedge clk_i) begin
      if (!rst_ni) begin
        assert_reset_state_R10: assert (!valid_o && data_o == '0)
          else $error("reset state not held");
      end
    end

    assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> valid_o == $past(valid_i));

    assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !$past(valid_i) |-> $stable(data_o));

    assert_zero_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && $past(valid_i) && $past(data_i) == '0 |-> data_o == '0);

    assert_zero_twid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && $past(valid_i) && $past(twid_i) == '0 |-> data_o == '0);
  end
endmodule

bind r4_bfly r4_bfly_chk #(.VW(VW), .REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
  .twid_i(twid_i), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/r4_bfly_test.sv
module r4_bfly_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] data_i = '0;
  logic [127:0] twid_i = '0;
  logic         valid_o;
  logic [127:0] data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic         exp_valid = 1'b0;
  logic [127:0] exp_data = '0;

  always #10 clk_i = ~clk_i;

  r4_bfly uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .twid_i(twid_i), .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic [31:0] cpx(input shortint re, input shortint im);
    return {re, im};
  endfunction

  // behavioural model: integer arithmetic, 16-bit wrap through shortint
  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] k);
    shortint mr[4], mi[4], yr[4], yi[4], zr[4], zi[4], dr, di;
    longint tr, ti, kr, ki;
    logic [127:0] r;
    for (int n = 0; n < 4; n++) begin
      tr = longint'(shortint'(d[32*n+16 +: 16]));
      ti = longint'(shortint'(d[32*n +: 16]));
      kr = longint'(shortint'(k[32*n+16 +: 16]));
      ki = longint'(shortint'(k[32*n +: 16]));
      mr[n] = shortint'((tr*kr - ti*ki) >>> 14);
      mi[n] = shortint'((tr*ki + ti*kr) >>> 14);
    end
    yr[0] = shortint'(mr[0] + mr[2]); yi[0] = shortint'(mi[0] + mi[2]);
    yr[1] = shortint'(mr[0] - mr[2]); yi[1] = shortint'(mi[0] - mi[2]);
    yr[2] = shortint'(mr[1] + mr[3]); yi[2] = shortint'(mi[1] + mi[3]);
    dr = shortint'(mr[1] - mr[3]);    di = shortint'(mi[1] - mi[3]);
    yr[3] = shortint'(-di);           yi[3] = dr;
    zr[0] = shortint'(yr[0] + yr[2]); zi[0] = shortint'(yi[0] + yi[2]);
    zr[1] = shortint'(yr[1] + yr[3]); zi[1] = shortint'(yi[1] + yi[3]);
    zr[2] = shortint'(yr[0] - yr[2]); zi[2] = shortint'(yi[0] - yi[2]);
    zr[3] = shortint'(yr[1] - yr[3]); zi[3] = shortint'(yi[1] - yi[3]);
    for (int n = 0; n < 4; n++) r[32*n +: 32] = cpx(zr[n], zi[n]);
    return r;
  endfunction

  task automatic check_bus(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s data_o actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_val(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s valid_o actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_half(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s field actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, model follows rising edge, compare at next falling edge
  task automatic step(input logic v, input logic [127:0] d, input logic [127:0] k, input string req);
    valid_i = v; data_i = d; twid_i = k;
    @(posedge clk_i);
    exp_valid = v;
    if (v) exp_data = model(d, k);
    @(negedge clk_i);
    check_val("R8", valid_o, exp_valid);
    check_bus(req, data_o, exp_data);
  endtask

  initial begin
    logic [127:0] unit_k, half_k, imag_k, d;
    logic [127:0] held;
    unit_k = {4{cpx(16'sh4000, 16'sh0000)}};
    half_k = {4{cpx(16'sh2000, 16'sh0000)}};
    imag_k = {4{cpx(16'sh0000, 16'sh4000)}};

    repeat (3) @(negedge clk_i);
    check_val("R10", valid_o, 1'b0);
    check_bus("R10", data_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5: only lane 1 nonzero, unit twiddles
    d = '0; d[32 +: 32] = cpx(16'sd100, 16'sd0);
    step(1'b1, d, unit_k, "R5");
    check_half("R5", data_o[32+16 +: 16], 16'sd0);
    check_half("R5", data_o[32 +: 16], 16'sd100);
    check_half("R5", data_o[96 +: 16], 16'hFF9C);
    check_half("R4", data_o[64+16 +: 16], 16'hFF9C);

    // R6: overflow wraps
    d = '0; d[0 +: 32] = cpx(16'sd32767, 16'sd0); d[64 +: 32] = cpx(16'sd32767, 16'sd0);
    step(1'b1, d, unit_k, "R6");
    check_half("R6", data_o[16 +: 16], 16'hFFFE);
    check_half("R6", data_o[64+16 +: 16], 16'hFFFE);

    // R2: half-scale twiddle and floor on negatives
    d = '0; d[0 +: 32] = cpx(16'sd1000, 16'sd0);
    step(1'b1, d, half_k, "R2");
    check_half("R2", data_o[96+16 +: 16], 16'sd500);
    d = '0; d[0 +: 32] = cpx(-16'sd3, 16'sd0);
    step(1'b1, d, half_k, "R2");
    check_half("R2", data_o[16 +: 16], 16'hFFFE);

    // R2 zero data, R1 lane packing with imaginary twiddle
    step(1'b1, '0, unit_k, "R2");
    d = {cpx(16'sd7, -16'sd9), cpx(-16'sd300, 16'sd41), cpx(16'sd1234, 16'sd5), cpx(-16'sd2, 16'sd88)};
    step(1'b1, d, imag_k, "R1");
    step(1'b1, d, unit_k, "R3");

    // R9: idle cycles hold output
    held = exp_data;
    step(1'b0, ~d, imag_k, "R9");
    check_bus("R9", data_o, held);
    step(1'b0, '1, '1, "R9");

    // R7: back-to-back and random traffic
    for (int i = 0; i < 400; i++) begin
      logic [127:0] rd, rk;
      for (int w = 0; w < 4; w++) begin
        rd[32*w +: 32] = $urandom();
        rk[32*w +: 32] = $urandom();
      end
      step(($urandom() % 4) != 0, rd, rk, "R7");
    end

    rst_ni = 1'b0;
    #1;
    check_val("R10", valid_o, 1'b0);
    check_bus("R10", data_o, '0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule